// File: doc/BRIEF.md
# Spare-Wire Repair Crossover for a Vertical Link

This block is the combinational repair logic of a die-to-die link that has N regular and R spare through-silicon wires. A fault map holds one bit per physical wire, and a 1 marks a faulty wire. From this map the block decides, one input at a time, where each of the N logical bits travels. Input 0 is placed first. Each later input takes the lowest fault-free wire at or above its own index that no lower input has already claimed. The same placement drives two switches. The transmit switch spreads N bits over N+R wires. The mirrored receive switch gathers the N+R wires back into N bits.

The block also counts the healthy wires. It raises one flag when the link still works but too few healthy wires remain for a full-width transfer, so the data has to be sent serially. It raises a second flag when fewer healthy wires remain than the configured floor, which means the link is dead. Flow-control signals belong on the lowest inputs, because those inputs are placed first. The fault map only changes after a test phase, so the long priority chain does not sit on the link's timing path.

Top module: `tsv_repair_xbar`

## Requirements
- R1: With an all-zero fault map, input i drives wire i, and its select has only bit 0 set.
- R2: Each input in turn, starting at input 0, goes to the lowest-indexed wire j >= i that is fault-free and that no lower-numbered input uses.
- R3: Each input's select is a W-bit field (W = N+R) at bit offset i*W of `shift_sel`. It is one-hot, and the index of its set bit is the shift, meaning wire index minus input index.
- R4: An input for which no wire is left has an all-zero select. It drives no wire, and its receive-side output is 0.
- R5: When at least MLIM wires are fault-free, inputs 0 to MLIM-1 are always placed.
- R6: `good_count` equals the number of 0 bits in the fault map.
- R7: `link_failed` is 1 exactly when good_count < MLIM. `ser_needed` is 1 exactly when MLIM <= good_count < N. The two flags are never both 1.
- R8: A wire that no input occupies is driven 0 on `tx_wires`.
- R9: `rx_data[i]` equals `rx_wires[j]`, where j is the wire that input i occupies under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fault_map | input | N+R | One bit per wire, 1 = faulty |
| tx_data | input | N | Logical bits to send |
| tx_wires | output | N+R | Physical wire drive |
| rx_wires | input | N+R | Physical wire samples |
| rx_data | output | N | Logical bits rebuilt from the wires |
| shift_sel | output | N*(N+R) | One-hot shift select per input, W bits each |
| good_count | output | $clog2(N+R+1) | Number of fault-free wires |
| ser_needed | output | 1 | Link works but needs several transfers per word |
| link_failed | output | 1 | Too few fault-free wires |

## Verification
The block is purely combinational, so a wrong occupancy mask in the priority chain is visible at the ports as soon as the fault map settles. When such a mask is wrong, two inputs share a wire, or an input skips a free wire, or an input lands on a faulty wire. Any of these changes `shift_sel` and `tx_wires` for that fault map. Every possible fault map is therefore applied, each with several data words, and the receive side is checked both on its own and by looping `tx_wires` back. This means a misrouted bit on either side shows up on the same fault map that exposes it.

// File: rtl/tsv_repair_pkg.sv
package tsv_repair_pkg;

    typedef enum logic [1:0] {
        LINK_FULL   = 2'd0,
        LINK_SERIAL = 2'd1,
        LINK_DEAD   = 2'd2
    } link_state_e;

    function automatic link_state_e classify_link(input int good, input int n_bits, input int floor_cnt);
        if (good < floor_cnt)
            return LINK_DEAD;
        else if (good < n_bits)
            return LINK_SERIAL;
        else
            return LINK_FULL;
    endfunction

endpackage

// File: rtl/tsv_alloc_chain.sv
module tsv_alloc_chain #(
    parameter int N = 4,
    parameter int R = 1,
    localparam int W = N + R
) (
    input  logic [W-1:0]          fault_map,
    output logic [N-1:0][W-1:0]   wire_oh,
    output logic [N-1:0][W-1:0]   shift_oh
);

    logic [N:0][W-1:0] taken;
    assign taken[0] = '0;

    for (genvar i = 0; i < N; i++) begin : g_stage
        logic [W-1:0] avail;
        logic [W-1:0] pick;
        always_comb begin
            avail = ~fault_map & ~taken[i] & ({W{1'b1}} << i);
            pick  = avail & (~avail + 1'b1);
        end
        assign wire_oh[i]  = pick;
        assign shift_oh[i] = pick >> i;
        assign taken[i+1]  = taken[i] | pick;

        always_comb begin
            assert_sel_onehot_R3: assert ($onehot0(shift_oh[i]))
                else $error("select of input %0d not one-hot", i);
        end
    end

endmodule

// File: rtl/tsv_tx_switch.sv
module tsv_tx_switch #(
    parameter int N = 4,
    parameter int R = 1,
    localparam int W = N + R
) (
    input  logic [N-1:0]          din,
    input  logic [N-1:0][W-1:0]   wire_oh,
    output logic [W-1:0]          wires
);

    logic [W-1:0] used;

    always_comb begin
        wires = '0;
        used  = '0;
        for (int i = 0; i < N; i++) begin
            wires = wires | (wire_oh[i] & {W{din[i]}});
            used  = used | wire_oh[i];
        end
    end

    always_comb begin
        assert_unused_low_R8: assert ((wires & ~used) == '0)
            else $error("unused wire driven");
    end

endmodule

// File: rtl/tsv_rx_switch.sv
module tsv_rx_switch #(
    parameter int N = 4,
    parameter int R = 1,
    localparam int W = N + R
) (
    input  logic [W-1:0]          wires,
    input  logic [N-1:0][W-1:0]   wire_oh,
    output logic [N-1:0]          dout
);

    for (genvar i = 0; i < N; i++) begin : g_out
        assign dout[i] = |(wire_oh[i] & wires);
    end

endmodule

// File: rtl/tsv_link_health.sv
module tsv_link_health
    import tsv_repair_pkg::*;
#(
    parameter int N    = 4,
    parameter int R    = 1,
    parameter int MLIM = 2,
    localparam int W  = N + R,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  fault_map,
    output logic [CW-1:0] good_count,
    output logic          ser_needed,
    output logic          link_failed
);

    link_state_e state;

    always_comb begin
        good_count = '0;
        for (int j = 0; j < W; j++)
            good_count = good_count + CW'(!fault_map[j]);
        state       = classify_link(int'(good_count), N, MLIM);
        ser_needed  = (state == LINK_SERIAL);
        link_failed = (state == LINK_DEAD);
    end

    always_comb begin
        assert_flags_excl_R7: assert (!(ser_needed && link_failed))
            else $error("both link flags set");
    end

endmodule

// File: rtl/tsv_repair_xbar.sv
module tsv_repair_xbar
    import tsv_repair_pkg::*;
#(
    parameter int N    = 4,
    parameter int R    = 1,
    parameter int MLIM = 2,
    localparam int W  = N + R,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]    fault_map,
    input  logic [N-1:0]    tx_data,
    output logic [W-1:0]    tx_wires,
    input  logic [W-1:0]    rx_wires,
    output logic [N-1:0]    rx_data,
    output logic [N*W-1:0]  shift_sel,
    output logic [CW-1:0]   good_count,
    output logic            ser_needed,
    output logic            link_failed
);

    logic [N-1:0][W-1:0] wire_oh;
    logic [N-1:0][W-1:0] shift_oh;

    tsv_alloc_chain #(.N(N), .R(R)) u_chain (
        .fault_map (fault_map),
        .wire_oh   (wire_oh),
        .shift_oh  (shift_oh)
    );

    tsv_tx_switch #(.N(N), .R(R)) u_tx (
        .din     (tx_data),
        .wire_oh (wire_oh),
        .wires   (tx_wires)
    );

    tsv_rx_switch #(.N(N), .R(R)) u_rx (
        .wires   (rx_wires),
        .wire_oh (wire_oh),
        .dout    (rx_data)
    );

    tsv_link_health #(.N(N), .R(R), .MLIM(MLIM)) u_health (
        .fault_map   (fault_map),
        .good_count  (good_count),
        .ser_needed  (ser_needed),
        .link_failed (link_failed)
    );

    assign shift_sel = shift_oh;

    always_comb begin
        int placed;
        placed = 0;
        for (int i = 0; i < N; i++)
            placed += (shift_oh[i] != '0) ? 1 : 0;
        assert_no_faulty_drive_R2: assert ((tx_wires & fault_map) == '0)
            else $error("faulty wire driven");
        assert_placed_count_R4: assert (placed == ((int'(good_count) < N) ? int'(good_count) : N))
            else $error("placed count %0d wrong", placed);
        if (!link_failed) begin
            for (int i = 0; i < MLIM && i < N; i++)
                assert_ctrl_placed_R5: assert (shift_oh[i] != '0)
                    else $error("low input %0d unplaced", i);
        end
    end

endmodule

// File: tb/tsv_repair_xbar_bench.sv
`timescale 1ns/1ps
module tsv_repair_xbar_bench;
    localparam int N = 4, R = 1, MLIM = 2;
    localparam int W = N + R;
    localparam int CW = $clog2(W + 1);

    logic clk = 0;
    logic rst = 1;
    always #2.5 clk = ~clk;

    logic [W-1:0]   fault_map = '0;
    logic [N-1:0]   tx_data = '0;
    logic [W-1:0]   tx_wires, rx_wires = '0;
    logic [N-1:0]   rx_data;
    logic [N*W-1:0] shift_sel;
    logic [CW-1:0]  good_count;
    logic           ser_needed, link_failed;

    int checks = 0, failures = 0;
    bit done = 0;

    tsv_repair_xbar #(.N(N), .R(R), .MLIM(MLIM)) u_tsv_repair_xbar (
        .fault_map(fault_map), .tx_data(tx_data), .tx_wires(tx_wires),
        .rx_wires(rx_wires), .rx_data(rx_data), .shift_sel(shift_sel),
        .good_count(good_count), .ser_needed(ser_needed), .link_failed(link_failed)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s fmap=%b act=%0h exp=%0h", req, fault_map, act, exp);
        end
    endtask

    // reference placement: pos[i] = wire of input i, -1 if none
    function automatic void ref_place(input logic [W-1:0] fm, output int pos [N]);
        logic [W-1:0] used = '0;
        for (int i = 0; i < N; i++) begin
            pos[i] = -1;
            for (int j = i; j < W; j++) begin
                if (pos[i] < 0 && !fm[j] && !used[j]) begin
                    pos[i] = j;
                    used[j] = 1'b1;
                end
            end
        end
    endfunction

    task automatic apply_and_check(input logic [W-1:0] fm, input logic [N-1:0] d, input logic [W-1:0] rw);
        int pos [N];
        logic [N*W-1:0] exp_sel = '0;
        logic [W-1:0] exp_tx = '0;
        logic [N-1:0] exp_rx = '0, exp_loop = '0;
        int good = 0;
        @(posedge clk); #1;
        fault_map = fm; tx_data = d; rx_wires = rw;
        @(negedge clk);
        ref_place(fm, pos);
        for (int j = 0; j < W; j++) good += fm[j] ? 0 : 1;
        for (int i = 0; i < N; i++) begin
            if (pos[i] >= 0) begin
                exp_sel[i*W + (pos[i] - i)] = 1'b1;
                exp_tx[pos[i]] = d[i];
                exp_rx[i] = rw[pos[i]];
                exp_loop[i] = d[i];
            end
        end
        chk("R2/R3/R4 shift_sel", 64'(shift_sel), 64'(exp_sel));
        chk("R2/R4/R8 tx_wires", 64'(tx_wires), 64'(exp_tx));
        chk("R9/R4 rx_data", 64'(rx_data), 64'(exp_rx));
        chk("R6 good_count", 64'(good_count), 64'(good));
        chk("R7 link_failed", 64'(link_failed), 64'(good < MLIM));
        chk("R7 ser_needed", 64'(ser_needed), 64'(good >= MLIM && good < N));
        if (good >= MLIM)
            for (int i = 0; i < MLIM; i++)
                chk("R5 low input placed", 64'(shift_sel[i*W +: W] != '0), 64'd1);
        // loopback: receive what was sent
        @(posedge clk); #1;
        rx_wires = tx_wires;
        @(negedge clk);
        chk("R9 loopback", 64'(rx_data), 64'(exp_loop));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        rst = 0;
        // R1: healthy link, identity mapping
        apply_and_check('0, 4'b1011, 5'b10110);
        for (int i = 0; i < N; i++)
            chk("R1 identity select", 64'(shift_sel[i*W +: W]), 64'd1);
        chk("R1 identity wires", 64'(tx_wires), 64'b01011);
        // directed corners
        apply_and_check(5'b00001, 4'b1111, 5'b11111);
        apply_and_check(5'b11100, 4'b1111, 5'b11111);
        apply_and_check(5'b11110, 4'b1111, 5'b11111);
        apply_and_check(5'b11111, 4'b1111, 5'b11111);
        // exhaustive fault maps, random data
        for (int f = 0; f < (1 << W); f++) begin
            apply_and_check(W'(f), {N{1'b1}}, '0);
            repeat (3) apply_and_check(W'(f), N'($urandom), W'($urandom));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule